// File: doc/BRIEF.md
# Address-Match Busy Arbiter

This block sits between the two ports of a shared memory. Every clock cycle it compares the left port's address with the right port's address. When both ports are enabled on the same address, it decides which port got there first. The port that arrived later receives an active-low busy indication, and its write strobe is gated off inside the block. The earlier port proceeds untouched. Only enable and address take part in the decision. Whether an access is a read or a write plays no part.

The block has a mode input. In master mode the block computes busy itself and drives it on the busy outputs. In slave mode the busy outputs stay inactive. The per-port busy inputs, which are normally taken from a master's outputs, then act only as write inhibits. A combined conflict output goes high when either port is inhibited, so it can serve as an illegal-access interrupt.

A port counts as "settled" in a cycle when it was enabled, at the same address, in the preceding cycle as well. Busy is registered. A decision made from the inputs in one cycle appears on the busy outputs after the next rising clock edge. Write gating then follows the busy state combinationally.

Top module: `busy_arbiter`

## Requirements
- R1: In master mode, if the ports do not match in a cycle, both busy outputs are high (inactive) after the next clock edge. A match means both enables are high and the two addresses are equal.
- R2: When a match begins and only one port is settled, the other port (the later arrival) has its busy output driven low after the next edge. The settled port's busy stays high.
- R3: When a match begins with both ports newly arrived, parameter TIE_LEFT_WINS picks the winner. With its default of 1, the right busy goes low. With 0, the left busy goes low.
- R4: The two busy outputs are never low at the same time.
- R5: The write inputs l_wr and r_wr have no effect on which port is marked busy.
- R6: While the match persists, the busy port stays busy, even if the losing port becomes settled. Once the match ends, busy releases after the following edge.
- R7: In master mode, a port's gated write output equals enable AND write AND NOT its internal busy state.
- R8: In slave mode, both busy outputs stay high. A port's busy input held low blocks that port's gated write in the same cycle. A busy input held high lets the write through.
- R9: The conflict output is high exactly when either port is currently inhibited. In master mode the inhibit is the port's busy state. In slave mode it is the port's busy input being low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = compute and drive busy, 0 = busy inputs act as write inhibits |
| l_en | input | 1 | Left port enable |
| l_addr | input | AW | Left port address |
| l_wr | input | 1 | Left port write strobe |
| l_busy_in_n | input | 1 | Left write inhibit, active low, used in slave mode |
| r_en | input | 1 | Right port enable |
| r_addr | input | AW | Right port address |
| r_wr | input | 1 | Right port write strobe |
| r_busy_in_n | input | 1 | Right write inhibit, active low, used in slave mode |
| l_busy_n | output | 1 | Left busy, active low |
| r_busy_n | output | 1 | Right busy, active low |
| l_we | output | 1 | Gated left write strobe |
| r_we | output | 1 | Gated right write strobe |
| conflict | output | 1 | Either port inhibited |

## Verification
The hardest situations to reach are the ordering cases. One is a match that begins with exactly one settled port. The other is a match that begins with both ports arriving in the same cycle. Random stimulus seldom holds an address steady long enough to create either one. Directed sequences therefore park one port for a cycle and then bring the other port onto the same address. They also move both ports onto a common address together, and keep a match alive while the loser settles. The address is narrowed to three bits, so random traffic also produces frequent matches, holds and releases.

// File: rtl/busy_arbiter.sv
module busy_arbiter #(
  parameter int AW = 19,
  parameter bit TIE_LEFT_WINS = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wr,
  input  logic          l_busy_in_n,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wr,
  input  logic          r_busy_in_n,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_we,
  output logic          r_we,
  output logic          conflict
);

  logic          l_en_q, r_en_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  logic          bl_q, br_q, bl_d, br_d;
  logic          match, l_settled, r_settled;
  logic          l_inh, r_inh;

  assign match     = l_en & r_en & (l_addr == r_addr);
  assign l_settled = l_en & l_en_q & (l_addr == l_addr_q);
  assign r_settled = r_en & r_en_q & (r_addr == r_addr_q);

  always_comb begin
    bl_d = 1'b0;
    br_d = 1'b0;
    if (match) begin
      if (bl_q | br_q) begin
        bl_d = bl_q;
        br_d = br_q;
      end else if (l_settled & ~r_settled) begin
        br_d = 1'b1;
      end else if (r_settled & ~l_settled) begin
        bl_d = 1'b1;
      end else if (TIE_LEFT_WINS) begin
        br_d = 1'b1;
      end else begin
        bl_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      bl_q     <= 1'b0;
      br_q     <= 1'b0;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      bl_q     <= bl_d;
      br_q     <= br_d;
    end
  end

  assign l_inh    = master_mode ? bl_q : ~l_busy_in_n;
  assign r_inh    = master_mode ? br_q : ~r_busy_in_n;
  assign l_busy_n = ~(master_mode & bl_q);
  assign r_busy_n = ~(master_mode & br_q);
  assign l_we     = l_en & l_wr & ~l_inh;
  assign r_we     = r_en & r_wr & ~r_inh;
  assign conflict = l_inh | r_inh;

endmodule

// File: rtl/busy_arbiter_chk.sv
module busy_arbiter_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_mode,
  input logic          l_en,
  input logic [AW-1:0] l_addr,
  input logic          l_wr,
  input logic          l_busy_in_n,
  input logic          r_en,
  input logic [AW-1:0] r_addr,
  input logic          r_wr,
  input logic          r_busy_in_n,
  input logic          l_busy_n,
  input logic          r_busy_n,
  input logic          l_we,
  input logic          r_we,
  input logic          conflict
);
  logic hit;
  assign hit = l_en & r_en & (l_addr == r_addr);

  assert_no_match_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !hit) |=> (l_busy_n && r_busy_n) || !master_mode);

  assert_exclusive_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  assert_hold_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && hit && !l_busy_n) |=> !l_busy_n || !master_mode);

  assert_hold_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && hit && !r_busy_n) |=> !r_busy_n || !master_mode);

  assert_gate_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |-> !l_we);

  assert_gate_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |-> !r_we);

  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (l_busy_n && r_busy_n));

  assert_slave_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && (!l_busy_in_n || !r_busy_in_n)) |-> conflict);
endmodule

bind busy_arbiter busy_arbiter_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_busy_arbiter.sv
module tb_busy_arbiter;
  localparam int AW = 3;
  logic clk = 1'b0, rst_n = 1'b0, mm = 1'b1;
  logic le = 0, lw = 0, lbi = 1, re = 0, rw = 0, rbi = 1;
  logic [AW-1:0] la = '0, ra = '0;
  logic lbn, rbn, lwe, rwe, cf;
  int checks = 0, errors = 0;
  logic ple = 0, pre = 0, ebl = 0, ebr = 0;
  logic [AW-1:0] pla = '0, pra = '0;

  always #5 clk = ~clk;

  busy_arbiter #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .master_mode(mm),
    .l_en(le), .l_addr(la), .l_wr(lw), .l_busy_in_n(lbi),
    .r_en(re), .r_addr(ra), .r_wr(rw), .r_busy_in_n(rbi),
    .l_busy_n(lbn), .r_busy_n(rbn), .l_we(lwe), .r_we(rwe), .conflict(cf));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] next_busy();
    logic m, ls, rs;
    m  = le & re & (la == ra);
    ls = le & ple & (la == pla);
    rs = re & pre & (ra == pra);
    if (!m) return 2'b00;
    if (ebl | ebr) return {ebl, ebr};
    if (ls & !rs) return 2'b01;
    if (rs & !ls) return 2'b10;
    return 2'b01;
  endfunction

  // called at negedge: check registered outputs, apply inputs, check gating, advance model
  task automatic step(input logic m, input logic e1, input logic [AW-1:0] a1, input logic w1, input logic b1,
                      input logic e2, input logic [AW-1:0] a2, input logic w2, input logic b2,
                      input string tag);
    logic [1:0] nb;
    logic il, ir;
    chk({tag, " R4"}, !(!lbn && !rbn), 1'b1);
    mm = m; le = e1; la = a1; lw = w1; lbi = b1; re = e2; ra = a2; rw = w2; rbi = b2;
    #1;
    chk({tag, " busyL R1/R2/R3/R6/R8"}, lbn, ~(m & ebl));
    chk({tag, " busyR R1/R2/R3/R6/R8"}, rbn, ~(m & ebr));
    il = m ? ebl : ~b1;
    ir = m ? ebr : ~b2;
    chk({tag, " weL R7/R8"}, lwe, e1 & w1 & ~il);
    chk({tag, " weR R7/R8"}, rwe, e2 & w2 & ~ir);
    chk({tag, " R9"}, cf, il | ir);
    nb = next_busy();
    ebl = nb[1]; ebr = nb[0];
    ple = le; pla = la; pre = re; pra = ra;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    chk("reset R1", lbn & rbn & ~cf, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: left settled, right joins -> right busy
    step(1, 1, 3'd5, 0, 1, 0, 3'd0, 0, 1, "R2a");
    step(1, 1, 3'd5, 0, 1, 1, 3'd5, 1, 1, "R2a");
    step(1, 1, 3'd5, 1, 1, 1, 3'd5, 1, 1, "R2a hold R6");
    chk("R2 right busy", rbn, 1'b0);
    step(1, 1, 3'd5, 1, 1, 1, 3'd5, 1, 1, "R6 hold");
    step(1, 1, 3'd5, 1, 1, 1, 3'd6, 1, 1, "R6 release");
    step(1, 0, 3'd0, 0, 1, 0, 3'd0, 0, 1, "R6 idle");
    chk("R6 released", rbn, 1'b1);
    // R2 mirrored, with reads only (R5)
    step(1, 0, 3'd0, 0, 1, 1, 3'd2, 0, 1, "R2b");
    step(1, 1, 3'd2, 0, 1, 1, 3'd2, 0, 1, "R2b R5");
    step(1, 1, 3'd2, 1, 1, 1, 3'd2, 1, 1, "R2b");
    chk("R2 left busy R5", lbn, 1'b0);
    step(1, 0, 3'd0, 0, 1, 0, 3'd0, 0, 1, "R2b drop");
    step(1, 0, 3'd0, 0, 1, 0, 3'd0, 0, 1, "idle");
    // R3 tie
    step(1, 1, 3'd7, 1, 1, 1, 3'd7, 0, 1, "R3");
    step(1, 1, 3'd7, 1, 1, 1, 3'd7, 1, 1, "R3");
    chk("R3 tie right busy", rbn, 1'b0);
    chk("R3 tie left free", lbn, 1'b1);
    step(1, 0, 3'd0, 0, 1, 0, 3'd0, 0, 1, "R3 drop");
    // R8 slave inhibit
    step(0, 1, 3'd1, 1, 0, 1, 3'd4, 1, 1, "R8 slave");
    chk("R8 left blocked", lwe, 1'b0);
    step(0, 1, 3'd1, 1, 1, 1, 3'd4, 1, 0, "R8 slave");
    chk("R8 right blocked", rwe, 1'b0);
    step(0, 1, 3'd3, 1, 1, 1, 3'd3, 1, 1, "R8 slave match");
    step(1, 0, 3'd0, 0, 1, 0, 3'd0, 0, 1, "back");
    step(1, 0, 3'd0, 0, 1, 0, 3'd0, 0, 1, "idle");
    // random
    for (int i = 0; i < 3000; i++) begin
      logic m, e1, e2, w1, w2, b1, b2;
      logic [AW-1:0] a1, a2;
      m  = ($urandom % 10) != 0;
      e1 = ($urandom % 4) != 0;
      e2 = ($urandom % 4) != 0;
      a1 = (($urandom % 3) == 0) ? AW'($urandom) : la;
      a2 = (($urandom % 3) == 0) ? AW'($urandom % 2) : ra;
      w1 = $urandom; w2 = $urandom;
      b1 = ($urandom % 4) != 0;
      b2 = ($urandom % 4) != 0;
      step(m, e1, a1, w1, b1, e2, a2, w2, b2, "rand");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule